// File: doc/BRIEF.md
# Coalesced Response Splitter

This block sits on the return path of a memory request coalescer. Each time a merged request goes out, the coalescer hands the splitter a record of which lanes and request slots were folded into it. It also supplies the tag that the merged request carries on the memory side. The splitter keeps these records in a small table that is indexed by that tag.

When the wide response comes back, the splitter reads the matching record in the same cycle. It then produces one response per lane and slot, each carrying the 32-bit word chosen by the slot's offset and the original requester's source ID. Once a response has been split, its record is freed.

The table has a fixed number of entries, one per in-flight merged request. While every entry is occupied, the block refuses new records. Any number of slots may point at the same word; each one gets its own copy.

Top module: `coal_resp_split`

## Requirements
- R1: After reset every table entry is free, `req_ready` is 1 and `out_valid` is all zeros.
- R2: A record is stored under `req_tag` on a rising edge where `req_valid` and `req_ready` are both 1. The record holds, for each slot k, a valid bit, a source ID, a word offset and a size code. Slot k = lane*2 + slot has its field at bits [k*W +: W] of the flat request port.
- R3: In a cycle with `rsp_valid` high and `rsp_tag` naming an occupied entry, `out_valid[k]` equals the stored valid bit of slot k in that same cycle. When `rsp_valid` is low, `out_valid` is all zeros.
- R4: A valid slot with word offset n returns bits [32n+31:32n] of `rsp_data`, with word 0 at the least significant end. Its result appears at `out_data[32k +: 32]`.
- R5: A valid slot returns its stored source ID on `out_src[4k +: 4]`. For a slot whose output is not valid, both `out_data` and `out_src` are zero.
- R6: Several lanes, and both slots of one lane, may carry the same offset; each of them receives the same word.
- R7: The size code selects how much of the chosen word is returned: 0 gives the low byte, 1 the low 16 bits, and 2 or 3 the full word. Unused upper bits are zero.
- R8: An entry is freed at the edge that ends its response cycle. A later response with the same tag, before a new record is written, produces no valid outputs.
- R9: While all 4 entries are occupied, `req_ready` is 0 and a request offered then is not stored: a later response to an occupied tag returns the earlier record.
- R10: A response whose tag names a free entry drives all of `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Record offered this cycle |
| req_ready | output | 1 | A free entry exists |
| req_tag | input | 2 | Tag of the merged request |
| req_slot_vld | input | 8 | Per-slot valid bits |
| req_slot_src | input | 32 | Per-slot original source IDs, 4 bits each |
| req_slot_off | input | 16 | Per-slot word offsets, 2 bits each |
| req_slot_size | input | 16 | Per-slot size codes, 2 bits each |
| rsp_valid | input | 1 | Wide response present |
| rsp_tag | input | 2 | Tag of the wide response |
| rsp_data | input | 128 | Wide response data |
| out_valid | output | 8 | Per-slot response valid |
| out_data | output | 256 | Per-slot response words, 32 bits each |
| out_src | output | 32 | Per-slot source IDs, 4 bits each |

## Verification
The bench builds the block with its defaults: 4 lanes of 2 slots, 128-bit responses, 4-bit source IDs and a 4-entry table. With only 4 entries, the table can be filled in four requests, which makes the full-table refusal and its recovery cheap to reach. With 4 words per response, every offset value is covered. The 8 slots allow lanes and slots to share a word, while others stay idle in the same response. The same dimensions keep the randomized requests short enough to mix every size code with every offset.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int LANES  = 4;
    localparam int SLOTS  = 2;
    localparam int NSLOT  = LANES * SLOTS;
    localparam int SRC_W  = 4;
    localparam int WORD_W = 32;
    localparam int DATA_W = 128;
    localparam int WORDS  = DATA_W / WORD_W;
    localparam int OFF_W  = $clog2(WORDS);
    localparam int SZ_W   = 2;
    localparam int DEPTH  = 4;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef struct packed {
        logic              vld;
        logic [SRC_W-1:0]  src;
        logic [OFF_W-1:0]  off;
        size_e             sz;
    } slot_t;

    // select one word by offset and trim it to the access size
    function automatic logic [WORD_W-1:0] pick_word(
        input logic [DATA_W-1:0] data,
        input logic [OFF_W-1:0]  off,
        input size_e             sz
    );
        logic [WORD_W-1:0] w;
        w = data[int'(off)*WORD_W +: WORD_W];
        case (sz)
            SZ_BYTE: pick_word = {{(WORD_W-8){1'b0}},  w[7:0]};
            SZ_HALF: pick_word = {{(WORD_W-16){1'b0}}, w[15:0]};
            default: pick_word = w;
        endcase
    endfunction

endpackage

// File: rtl/crs_entry_table.sv
module crs_entry_table
    import crs_pkg::*;
#(
    parameter int TBL_DEPTH = crs_pkg::DEPTH,
    localparam int TAG_W    = $clog2(TBL_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [TAG_W-1:0]       wr_tag,
    input  slot_t [NSLOT-1:0]      wr_slots,
    input  logic                   rd_en,
    input  logic [TAG_W-1:0]       rd_tag,
    output logic                   rd_hit,
    output slot_t [NSLOT-1:0]      rd_slots,
    output logic [TBL_DEPTH-1:0]   occ,
    output logic                   full
);

    slot_t [NSLOT-1:0] mem [TBL_DEPTH];
    logic  [TBL_DEPTH-1:0] occ_q;

    for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_entry
        logic set_e, clr_e;
        assign set_e = wr_en && (int'(wr_tag) == e);
        assign clr_e = rd_en && (int'(rd_tag) == e);

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q[e] <= 1'b0;
            end else if (set_e) begin
                occ_q[e] <= 1'b1;       // a new record wins over a free
            end else if (clr_e) begin
                occ_q[e] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (set_e) begin
                mem[e] <= wr_slots;
            end
        end
    end

    assign rd_hit   = rd_en && occ_q[rd_tag];
    assign rd_slots = mem[rd_tag];
    assign occ      = occ_q;
    assign full     = &occ_q;

endmodule

// File: rtl/crs_word_pick.sv
module crs_word_pick
    import crs_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  slot_t             slot,
    input  logic              hit,
    output logic              valid,
    output logic [WORD_W-1:0] word,
    output logic [SRC_W-1:0]  src
);

    assign valid = hit && slot.vld;
    assign word  = valid ? pick_word(data, slot.off, slot.sz) : '0;
    assign src   = valid ? slot.src : '0;

endmodule

// File: rtl/coal_resp_split.sv
module coal_resp_split
    import crs_pkg::*;
#(
    parameter int TBL_DEPTH = crs_pkg::DEPTH,
    localparam int TAG_W    = $clog2(TBL_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic [NSLOT-1:0]        req_slot_vld,
    input  logic [NSLOT*SRC_W-1:0]  req_slot_src,
    input  logic [NSLOT*OFF_W-1:0]  req_slot_off,
    input  logic [NSLOT*SZ_W-1:0]   req_slot_size,
    input  logic                    rsp_valid,
    input  logic [TAG_W-1:0]        rsp_tag,
    input  logic [DATA_W-1:0]       rsp_data,
    output logic [NSLOT-1:0]        out_valid,
    output logic [NSLOT*WORD_W-1:0] out_data,
    output logic [NSLOT*SRC_W-1:0]  out_src
);

    slot_t [NSLOT-1:0]    wr_slots;
    slot_t [NSLOT-1:0]    rd_slots;
    logic                 rd_hit;
    logic                 tbl_full;
    logic [TBL_DEPTH-1:0] tbl_occ;
    logic                 accept;

    for (genvar k = 0; k < NSLOT; k++) begin : g_pack
        assign wr_slots[k].vld = req_slot_vld[k];
        assign wr_slots[k].src = req_slot_src[k*SRC_W +: SRC_W];
        assign wr_slots[k].off = req_slot_off[k*OFF_W +: OFF_W];
        assign wr_slots[k].sz  = size_e'(req_slot_size[k*SZ_W +: SZ_W]);
    end

    assign req_ready = !tbl_full;
    assign accept    = req_valid && req_ready;

    crs_entry_table #(.TBL_DEPTH(TBL_DEPTH)) i_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_tag   (req_tag),
        .wr_slots (wr_slots),
        .rd_en    (rsp_valid),
        .rd_tag   (rsp_tag),
        .rd_hit   (rd_hit),
        .rd_slots (rd_slots),
        .occ      (tbl_occ),
        .full     (tbl_full)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        crs_word_pick i_pick (
            .data  (rsp_data),
            .slot  (rd_slots[k]),
            .hit   (rd_hit),
            .valid (out_valid[k]),
            .word  (out_data[k*WORD_W +: WORD_W]),
            .src   (out_src[k*SRC_W +: SRC_W])
        );
    end

endmodule

// File: rtl/crs_checker.sv
module crs_checker
    import crs_pkg::*;
#(
    parameter int TBL_DEPTH = crs_pkg::DEPTH,
    localparam int TAG_W    = $clog2(TBL_DEPTH)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [TAG_W-1:0]        req_tag,
    input logic                    rsp_valid,
    input logic [TAG_W-1:0]        rsp_tag,
    input logic [NSLOT-1:0]        out_valid,
    input logic [NSLOT*WORD_W-1:0] out_data,
    input logic [TBL_DEPTH-1:0]    tbl_occ,
    input logic                    rd_hit,
    input slot_t [NSLOT-1:0]       rd_slots
);

    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> tbl_occ[$past(req_tag)]);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (out_valid == '0));

    p_free_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !(req_valid && req_ready && req_tag == rsp_tag))
        |=> !tbl_occ[$past(rsp_tag)]);

    p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !rsp_valid) |=> !req_ready);

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rd_hit) |-> (out_valid == '0));

    for (genvar k = 0; k < NSLOT; k++) begin : g_sz
        p_byte_zext_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[k] && rd_slots[k].sz == SZ_BYTE)
            |-> (out_data[k*WORD_W+8 +: WORD_W-8] == '0));
        p_half_zext_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[k] && rd_slots[k].sz == SZ_HALF)
            |-> (out_data[k*WORD_W+16 +: WORD_W-16] == '0));
    end

endmodule

bind coal_resp_split crs_checker #(.TBL_DEPTH(TBL_DEPTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .out_valid (out_valid),
    .out_data  (out_data),
    .tbl_occ   (tbl_occ),
    .rd_hit    (rd_hit),
    .rd_slots  (rd_slots)
);

// File: tb/test_coal_resp_split.sv
module test_coal_resp_split;
    import crs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = $clog2(DEPTH);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [TAG_W-1:0]        req_tag = '0;
    logic [NSLOT-1:0]        req_slot_vld = '0;
    logic [NSLOT*SRC_W-1:0]  req_slot_src = '0;
    logic [NSLOT*OFF_W-1:0]  req_slot_off = '0;
    logic [NSLOT*SZ_W-1:0]   req_slot_size = '0;
    logic                    rsp_valid = 1'b0;
    logic [TAG_W-1:0]        rsp_tag = '0;
    logic [DATA_W-1:0]       rsp_data = '0;
    logic [NSLOT-1:0]        out_valid;
    logic [NSLOT*WORD_W-1:0] out_data;
    logic [NSLOT*SRC_W-1:0]  out_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_resp_split i_coal_resp_split (.*);

    typedef struct {
        logic [NSLOT-1:0]        vld;
        logic [NSLOT*WORD_W-1:0] data;
        logic [NSLOT*SRC_W-1:0]  src;
        string                   tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    // bench model of the table
    bit          m_occ [DEPTH];
    logic        m_vld [DEPTH][NSLOT];
    logic [3:0]  m_src [DEPTH][NSLOT];
    logic [1:0]  m_off [DEPTH][NSLOT];
    logic [1:0]  m_sz  [DEPTH][NSLOT];

    // staging for the next request
    logic        b_vld [NSLOT];
    logic [3:0]  b_src [NSLOT];
    logic [1:0]  b_off [NSLOT];
    logic [1:0]  b_sz  [NSLOT];

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_stage();
        for (int k = 0; k < NSLOT; k++) begin
            b_vld[k] = 0; b_src[k] = 0; b_off[k] = 0; b_sz[k] = 2;
        end
    endtask

    // R2: record offered; stored only if the model has a free entry (R9)
    task automatic issue(input int tag);
        bit all_busy;
        all_busy = 1;
        for (int e = 0; e < DEPTH; e++) if (!m_occ[e]) all_busy = 0;
        @(posedge clk); #1;
        req_valid = 1; req_tag = TAG_W'(tag);
        for (int k = 0; k < NSLOT; k++) begin
            req_slot_vld[k] = b_vld[k];
            req_slot_src[k*SRC_W +: SRC_W] = b_src[k];
            req_slot_off[k*OFF_W +: OFF_W] = b_off[k];
            req_slot_size[k*SZ_W +: SZ_W]  = b_sz[k];
        end
        if (!all_busy) begin
            m_occ[tag] = 1;
            for (int k = 0; k < NSLOT; k++) begin
                m_vld[tag][k] = b_vld[k]; m_src[tag][k] = b_src[k];
                m_off[tag][k] = b_off[k]; m_sz[tag][k]  = b_sz[k];
            end
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic respond(input int tag, input logic [127:0] d, input string lbl);
        exp_t e;
        logic [31:0] w;
        e.vld = '0; e.data = '0; e.src = '0; e.tag = lbl;
        if (m_occ[tag]) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (m_vld[tag][k]) begin
                    w = 32'(d >> (32 * int'(m_off[tag][k])));
                    if (m_sz[tag][k] == 0) w = w & 32'h0000_00ff;
                    else if (m_sz[tag][k] == 1) w = w & 32'h0000_ffff;
                    e.vld[k] = 1'b1;
                    e.data[k*32 +: 32] = w;
                    e.src[k*4 +: 4] = m_src[tag][k];
                end
            end
            m_occ[tag] = 0;   // R8
        end
        @(posedge clk); #1;
        rsp_valid = 1; rsp_tag = TAG_W'(tag); rsp_data = d;
        exp_q.push_back(e);
        @(posedge clk); #1;
        rsp_valid = 0;
    endtask

    // monitor: compare every response cycle with the scoreboard head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 actual=unexpected response expected=none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({"R3 valid ", e.tag}, 256'(out_valid), 256'(e.vld));
                check({"R4 data ", e.tag},  256'(out_data),  256'(e.data));
                check({"R5 src ", e.tag},   256'(out_src),   256'(e.src));
            end
        end
    end

    localparam logic [127:0] LIT = 128'h0123456789abcdef_5ca1ab1edeadbeef;

    initial begin
        for (int e = 0; e < DEPTH; e++) m_occ[e] = 0;
        clear_stage();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 ready after reset", 256'(req_ready), 256'(1));
        check("R1 no output after reset", 256'(out_valid), 256'(0));

        // R6: two slots of lane 0 share offset 1; lane 2 uses offsets 2 and 3
        clear_stage();
        b_vld[0] = 1; b_src[0] = 1; b_off[0] = 1;
        b_vld[1] = 1; b_src[1] = 2; b_off[1] = 1;
        b_vld[4] = 1; b_src[4] = 2; b_off[4] = 2;
        b_vld[5] = 1; b_src[5] = 2; b_off[5] = 3;
        issue(0);
        respond(0, LIT, "R6 shared offset in lane");

        // R6: every lane slot 0 at offset 1
        clear_stage();
        for (int l = 0; l < LANES; l++) begin
            b_vld[2*l] = 1; b_src[2*l] = 4'(l); b_off[2*l] = 1;
        end
        issue(1);
        respond(1, LIT, "R6 shared offset across lanes");

        // R7: size codes
        clear_stage();
        b_vld[0] = 1; b_src[0] = 7;  b_off[0] = 0; b_sz[0] = 0;
        b_vld[1] = 1; b_src[1] = 8;  b_off[1] = 3; b_sz[1] = 1;
        b_vld[2] = 1; b_src[2] = 9;  b_off[2] = 2; b_sz[2] = 2;
        b_vld[3] = 1; b_src[3] = 15; b_off[3] = 1; b_sz[3] = 3;
        b_vld[7] = 1; b_src[7] = 3;  b_off[7] = 0; b_sz[7] = 1;
        issue(2);
        respond(2, LIT, "R7 sizes");
        // R8: second response to a freed tag yields nothing
        respond(2, LIT, "R8 freed tag");
        // R10: never-written tag
        respond(3, LIT, "R10 free tag");

        // R9: fill the table
        for (int t = 0; t < DEPTH; t++) begin
            clear_stage();
            b_vld[t] = 1; b_src[t] = 4'(t + 10); b_off[t] = 2'(t);
            issue(t);
        end
        @(negedge clk);
        check("R9 ready low when full", 256'(req_ready), 256'(0));
        clear_stage();
        for (int k = 0; k < NSLOT; k++) begin b_vld[k] = 1; b_src[k] = 4'hf; end
        issue(0);   // refused, model unchanged
        respond(0, LIT, "R9 refused request ignored");
        @(negedge clk);
        check("R8 ready after free", 256'(req_ready), 256'(1));
        for (int t = 1; t < DEPTH; t++) respond(t, LIT, "R9 drain");

        // mixed patterns
        for (int i = 0; i < 24; i++) begin
            logic [127:0] d;
            d = {$urandom(), $urandom(), $urandom(), $urandom()};
            for (int k = 0; k < NSLOT; k++) begin
                b_vld[k] = 1'($urandom()); b_src[k] = 4'($urandom());
                b_off[k] = 2'($urandom()); b_sz[k]  = 2'($urandom());
            end
            issue(i % DEPTH);
            respond(i % DEPTH, d, "R4 mixed");
        end

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R3 actual=%0d pending expected=0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule